// File: doc/BRIEF.md
# Snapshotting Activity Counter Bank

This block keeps a set of always-running 64-bit counters for one core or cache slice. Each counter is tied to one class of retired instruction: floating point, atomic, branch, integer, load/store, SIMD/vector and miscellaneous. An eighth counter keeps the total of all retired instructions. Each class input is a single-cycle pulse. The total counter advances by the number of class pulses seen in that cycle.

Two latch banks sit behind the counters. The privileged bank is read by the operating system and the user bank is read by the application. Each bank has its own snapshot trigger. When a trigger fires, the whole counter set is copied into that bank in one clock cycle, so a reader always sees a consistent image. A trigger comes either from a manual request or from a per-bank divider. The divider counts strobes derived from a global real-time tick. That tick is asynchronous to the core clock and is not affected by core frequency scaling.

Software reads a bank through a registered port: it selects a bank and a counter index, and the value appears one cycle later. Each bank also shows a sequence number that advances on every snapshot, so a reader can tell whether a new image arrived between two reads.

Top module: `actctr_bank`

## Requirements
- R1: After reset every live counter, every latched value, both sequence numbers and the read data are zero.
- R2: Counter k (k = 0 fp, 1 atomic, 2 branch, 3 integer, 4 load/store, 5 SIMD/vector, 6 misc) increments by exactly one in every cycle its pulse `evt_i[k]` is high. It has no enable.
- R3: Counter 7 (total) increments in each cycle by the number of bits of `evt_i` that are high.
- R4: A snapshot copies all eight live counters into the bank in the same cycle. An event in the snapshot cycle is missing from the latched image but present in the live count, so a later snapshot shows it.
- R5: The two banks are independent. A snapshot of one bank leaves the other bank's values and sequence number unchanged.
- R6: Each rising edge of the asynchronous `gtick_i` produces exactly one internal strobe. With a divider value N > 0, the bank snapshots once every N strobes.
- R7: A divider value of zero stops periodic snapshots for that bank. A manual request (`os_snap_i` / `app_snap_i`) still snapshots in the cycle it is high.
- R8: The read port returns the latched value of bank `rd_bank_i` (0 = OS, 1 = application) and counter `rd_idx_i` on the cycle after the request. An index of 8 or above returns zero.
- R9: Each bank's sequence number increases by one on every snapshot of that bank and wraps modulo 2^SEQ_W.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 7 | Per-class retired-instruction pulses |
| gtick_i | input | 1 | Global real-time tick, asynchronous |
| os_div_i | input | DIV_W | OS bank period in strobes, 0 = off |
| app_div_i | input | DIV_W | Application bank period in strobes, 0 = off |
| os_snap_i | input | 1 | Manual OS snapshot request |
| app_snap_i | input | 1 | Manual application snapshot request |
| rd_bank_i | input | 1 | Read bank select, 0 = OS, 1 = application |
| rd_idx_i | input | IDX_W | Read counter index |
| rd_data_o | output | CNT_W | Latched value, one cycle after the request |
| os_seq_o | output | SEQ_W | OS bank snapshot sequence number |
| app_seq_o | output | SEQ_W | Application bank snapshot sequence number |

## Verification
The live counters cannot be seen at the ports. The case that an event coinciding with a snapshot is excluded from the image can therefore only be shown by comparing two images. The stimulus raises every event pulse in the same cycle as an OS request and reads the OS bank. It then takes an application snapshot with no events and checks that the difference between the two banks is exactly the coincident events. Sequence wrap is reached by holding a manual request high for 2^SEQ_W cycles. Periodic behaviour is reached by driving tick trains with divider values that differ per bank, then comparing sequence deltas.

// File: rtl/actctr_pkg.sv
package actctr_pkg;
    // Fixed event classes; the position is the counter index and the read index
    typedef enum logic [2:0] {
        EV_FP     = 3'd0,
        EV_ATOMIC = 3'd1,
        EV_BRANCH = 3'd2,
        EV_INT    = 3'd3,
        EV_LDST   = 3'd4,
        EV_SIMD   = 3'd5,
        EV_MISC   = 3'd6
    } ev_class_e;

    localparam int NUM_CLASSES = 7;
    localparam int NUM_CTRS    = NUM_CLASSES + 1;  // classes plus the total
    localparam int TOTAL_IDX   = NUM_CLASSES;
endpackage

// File: rtl/actctr_tick_sync.sv
module actctr_tick_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    output logic strobe_o
);
    typedef struct packed {
        logic [2:0] sh;   // [0],[1] synchronizer, [2] edge history
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.sh = {st_q.sh[1:0], tick_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign strobe_o = st_q.sh[1] & ~st_q.sh[2];

    // R6: a strobe never lasts two cycles
    a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |=> !strobe_o);
endmodule

// File: rtl/actctr_snap_timer.sv
module actctr_snap_timer #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             req_i,
    output logic             snap_o
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } st_t;

    st_t  st_d, st_q;
    logic period_hit;

    always_comb begin
        st_d       = st_q;
        period_hit = strobe_i && (div_i != '0) && (st_q.cnt >= div_i - DIV_W'(1));
        if (div_i == '0) begin
            st_d.cnt = '0;
        end else if (strobe_i) begin
            st_d.cnt = period_hit ? '0 : st_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign snap_o = period_hit | req_i;

    // R7: with a zero period only a manual request can trigger
    a_r7_zero_div_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (div_i == '0 && !req_i) |-> !snap_o);
    // R6: periodic snapshots only land on a tick strobe
    a_r6_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (snap_o && !req_i) |-> strobe_i);
endmodule

// File: rtl/actctr_counters.sv
module actctr_counters #(
    parameter int NUM_EV = 7,
    parameter int CNT_W  = 64,
    localparam int NCTR  = NUM_EV + 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_EV-1:0]          evt_i,
    output logic [NCTR-1:0][CNT_W-1:0] cnt_o
);
    typedef struct packed {
        logic [NCTR-1:0][CNT_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_EV; i++) begin
            if (evt_i[i]) st_d.cnt[i] = st_q.cnt[i] + CNT_W'(1);
        end
        st_d.cnt[NUM_EV] = st_q.cnt[NUM_EV] + CNT_W'($countones(evt_i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

    generate
        for (genvar g = 0; g < NUM_EV; g++) begin : g_chk
            // R2: a class counter moves by at most one per cycle
            a_r2_class_step: assert property (@(posedge clk) disable iff (!rst_n)
                (st_q.cnt[g] - $past(st_q.cnt[g])) <= CNT_W'(1));
        end
    endgenerate

    // R3: the total moves by at most the number of classes per cycle
    a_r3_total_step: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt[NUM_EV] - $past(st_q.cnt[NUM_EV])) <= CNT_W'(NUM_EV));
endmodule

// File: rtl/actctr_latch_bank.sv
module actctr_latch_bank #(
    parameter int NCTR  = 8,
    parameter int CNT_W = 64,
    parameter int SEQ_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       snap_i,
    input  logic [NCTR-1:0][CNT_W-1:0] cnt_i,
    output logic [NCTR-1:0][CNT_W-1:0] lat_o,
    output logic [SEQ_W-1:0]           seq_o
);
    typedef struct packed {
        logic [NCTR-1:0][CNT_W-1:0] lat;
        logic [SEQ_W-1:0]           seq;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (snap_i) begin
            st_d.lat = cnt_i;
            st_d.seq = st_q.seq + SEQ_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lat_o = st_q.lat;
    assign seq_o = st_q.seq;

    // R4: the image only changes on a snapshot
    a_r4_hold_image: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_i |=> $stable(st_q.lat));
    // R9: every snapshot advances the sequence by one, wrapping
    a_r9_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
        snap_i |=> (st_q.seq == SEQ_W'($past(st_q.seq) + SEQ_W'(1))));
endmodule

// File: rtl/actctr_bank.sv
module actctr_bank
    import actctr_pkg::*;
#(
    parameter int CNT_W = 64,
    parameter int DIV_W = 16,
    parameter int SEQ_W = 16,
    parameter int IDX_W = $clog2(NUM_CTRS) + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_CLASSES-1:0] evt_i,
    input  logic                   gtick_i,
    input  logic [DIV_W-1:0]       os_div_i,
    input  logic [DIV_W-1:0]       app_div_i,
    input  logic                   os_snap_i,
    input  logic                   app_snap_i,
    input  logic                   rd_bank_i,
    input  logic [IDX_W-1:0]       rd_idx_i,
    output logic [CNT_W-1:0]       rd_data_o,
    output logic [SEQ_W-1:0]       os_seq_o,
    output logic [SEQ_W-1:0]       app_seq_o
);
    localparam int NBANK = 2;

    logic                           strobe;
    logic [NUM_CTRS-1:0][CNT_W-1:0] live;
    logic [DIV_W-1:0]               div_a  [NBANK];
    logic                           req_a  [NBANK];
    logic                           snap_a [NBANK];
    logic [NUM_CTRS-1:0][CNT_W-1:0] lat_a  [NBANK];
    logic [SEQ_W-1:0]               seq_a  [NBANK];

    assign div_a[0] = os_div_i;
    assign div_a[1] = app_div_i;
    assign req_a[0] = os_snap_i;
    assign req_a[1] = app_snap_i;

    actctr_tick_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (gtick_i),
        .strobe_o (strobe)
    );

    actctr_counters #(.NUM_EV(NUM_CLASSES), .CNT_W(CNT_W)) u_ctrs (
        .clk   (clk),
        .rst_n (rst_n),
        .evt_i (evt_i),
        .cnt_o (live)
    );

    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_bank
            actctr_snap_timer #(.DIV_W(DIV_W)) u_timer (
                .clk      (clk),
                .rst_n    (rst_n),
                .strobe_i (strobe),
                .div_i    (div_a[b]),
                .req_i    (req_a[b]),
                .snap_o   (snap_a[b])
            );
            actctr_latch_bank #(.NCTR(NUM_CTRS), .CNT_W(CNT_W), .SEQ_W(SEQ_W)) u_latch (
                .clk    (clk),
                .rst_n  (rst_n),
                .snap_i (snap_a[b]),
                .cnt_i  (live),
                .lat_o  (lat_a[b]),
                .seq_o  (seq_a[b])
            );
        end
    endgenerate

    assign os_seq_o  = seq_a[0];
    assign app_seq_o = seq_a[1];

    typedef struct packed {
        logic [CNT_W-1:0] rd;
    } rd_st_t;

    rd_st_t                         rd_d, rd_q;
    logic [NUM_CTRS-1:0][CNT_W-1:0] sel_bank;

    always_comb begin
        rd_d     = '0;
        sel_bank = rd_bank_i ? lat_a[1] : lat_a[0];
        for (int k = 0; k < NUM_CTRS; k++) begin
            if (rd_idx_i == IDX_W'(k)) rd_d.rd = sel_bank[k];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_data_o = rd_q.rd;

    // R8: an index past the last counter reads as zero
    a_r8_oob_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_idx_i) >= IDX_W'(NUM_CTRS)) |-> (rd_data_o == '0));
    // R5: a bank whose trigger is idle keeps its sequence number
    a_r5_os_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_a[0] |=> $stable(os_seq_o));
    a_r5_app_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_a[1] |=> $stable(app_seq_o));
endmodule

// File: tb/actctr_bank_test.sv
module actctr_bank_test;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 64;
    localparam int DIV_W = 16;
    localparam int SEQ_W = 16;
    localparam int IDX_W = 4;
    localparam int NCLS  = 7;
    localparam int NCTR  = 8;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NCLS-1:0]    evt = '0;
    logic               gtick = 1'b0;
    logic [DIV_W-1:0]   os_div = '0;
    logic [DIV_W-1:0]   app_div = '0;
    logic               os_snap = 1'b0;
    logic               app_snap = 1'b0;
    logic               rd_bank = 1'b0;
    logic [IDX_W-1:0]   rd_idx = '0;
    logic [CNT_W-1:0]   rd_data;
    logic [SEQ_W-1:0]   os_seq;
    logic [SEQ_W-1:0]   app_seq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [CNT_W-1:0] exp_live [NCTR];
    logic [CNT_W-1:0] exp_os   [NCTR];
    logic [CNT_W-1:0] exp_app  [NCTR];
    logic [SEQ_W-1:0] exp_os_seq = '0;
    logic [SEQ_W-1:0] exp_app_seq = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    actctr_bank #(.CNT_W(CNT_W), .DIV_W(DIV_W), .SEQ_W(SEQ_W), .IDX_W(IDX_W)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt),
        .gtick_i    (gtick),
        .os_div_i   (os_div),
        .app_div_i  (app_div),
        .os_snap_i  (os_snap),
        .app_snap_i (app_snap),
        .rd_bank_i  (rd_bank),
        .rd_idx_i   (rd_idx),
        .rd_data_o  (rd_data),
        .os_seq_o   (os_seq),
        .app_seq_o  (app_seq)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One cycle: drive at a falling edge, model the rising edge, clear
    task automatic step(input logic [NCLS-1:0] ev, input logic os_r, input logic app_r);
        evt = ev; os_snap = os_r; app_snap = app_r;
        @(posedge clk);
        if (os_r) begin
            for (int k = 0; k < NCTR; k++) exp_os[k] = exp_live[k];
            exp_os_seq++;
        end
        if (app_r) begin
            for (int k = 0; k < NCTR; k++) exp_app[k] = exp_live[k];
            exp_app_seq++;
        end
        for (int k = 0; k < NCLS; k++) if (ev[k]) exp_live[k]++;
        exp_live[NCLS] += CNT_W'($countones(ev));
        @(negedge clk);
        evt = '0; os_snap = 1'b0; app_snap = 1'b0;
    endtask

    task automatic read_chk(input logic bank, input int idx, input logic [63:0] exp, input string req);
        logic [63:0] got;
        rd_bank = bank; rd_idx = IDX_W'(idx);
        @(posedge clk);
        @(negedge clk);
        got = rd_data;
        check(got == exp, req, got, exp);
    endtask

    task automatic check_bank(input logic bank, input string req);
        for (int k = 0; k < NCTR; k++)
            read_chk(bank, k, bank ? exp_app[k] : exp_os[k], req);
    endtask

    task automatic check_seqs(input string req);
        check(os_seq == exp_os_seq, req, 64'(os_seq), 64'(exp_os_seq));
        check(app_seq == exp_app_seq, req, 64'(app_seq), 64'(exp_app_seq));
    endtask

    task automatic tick_train(input int n, input int hi, input int lo);
        for (int t = 0; t < n; t++) begin
            gtick = 1'b1;
            repeat (hi) @(negedge clk);
            gtick = 1'b0;
            repeat (lo) @(negedge clk);
        end
        repeat (5) @(negedge clk);
    endtask

    task automatic t_reset;
        // R1: all state is zero after reset
        check(rd_data == '0, "R1", rd_data, 64'd0);
        check_seqs("R1");
        check_bank(1'b0, "R1");
        check_bank(1'b1, "R1");
    endtask

    task automatic t_counting;
        // R2, R3: varied pulse patterns, then an idle OS snapshot
        for (int k = 0; k < NCLS; k++) step(NCLS'(1) << k, 1'b0, 1'b0);
        step(7'b1010101, 1'b0, 1'b0);
        step(7'b1111111, 1'b0, 1'b0);
        step(7'b0000011, 1'b0, 1'b0);
        step(7'b0000000, 1'b0, 1'b0);
        step(7'b1001000, 1'b0, 1'b0);
        step(7'b0, 1'b1, 1'b0);
        for (int k = 0; k < NCLS; k++) read_chk(1'b0, k, exp_os[k], "R2");
        read_chk(1'b0, NCLS, exp_os[NCLS], "R3");
    endtask

    task automatic t_coincident;
        logic [63:0] os_total;
        // R4: events in the snapshot cycle are excluded from the image
        step(7'b1111111, 1'b1, 1'b0);
        check_bank(1'b0, "R4");
        os_total = exp_os[NCLS];
        // R5: OS snapshots left the application bank untouched
        check_bank(1'b1, "R5");
        step(7'b0, 1'b0, 1'b1);
        check_bank(1'b1, "R4");
        read_chk(1'b1, NCLS, os_total + 64'd7, "R4");
        check_seqs("R9");
    endtask

    task automatic t_independent;
        // R5: an application snapshot leaves the OS bank and sequence alone
        step(7'b0110011, 1'b0, 1'b0);
        step(7'b0, 1'b0, 1'b1);
        check_bank(1'b0, "R5");
        check_seqs("R5");
        check_bank(1'b1, "R5");
    endtask

    task automatic t_bad_index;
        // R8: indices 8..15 read as zero in both banks
        for (int k = NCTR; k < 16; k++) begin
            read_chk(1'b0, k, 64'd0, "R8");
            read_chk(1'b1, k, 64'd0, "R8");
        end
    endtask

    task automatic t_periodic;
        // R6: OS divider 3 over 12 ticks gives 4, app divider 1 gives 12
        os_div = DIV_W'(3); app_div = DIV_W'(1);
        step(7'b0010100, 1'b0, 1'b0);
        tick_train(12, 6, 6);
        exp_os_seq += SEQ_W'(4);
        exp_app_seq += SEQ_W'(12);
        for (int k = 0; k < NCTR; k++) begin
            exp_os[k] = exp_live[k];
            exp_app[k] = exp_live[k];
        end
        check_seqs("R6");
        check_bank(1'b0, "R6");
        check_bank(1'b1, "R6");
    endtask

    task automatic t_div_zero;
        // R7: zero dividers ignore ticks, manual requests still work
        os_div = '0; app_div = '0;
        step(7'b1000001, 1'b0, 1'b0);
        tick_train(5, 4, 4);
        check_seqs("R7");
        check_bank(1'b0, "R7");
        step(7'b0, 1'b1, 1'b0);
        check_seqs("R7");
        check_bank(1'b0, "R7");
    endtask

    task automatic t_seq_wrap;
        // R9: 2^SEQ_W back-to-back snapshots bring the sequence round
        app_snap = 1'b1;
        repeat (1 << SEQ_W) @(negedge clk);
        app_snap = 1'b0;
        for (int k = 0; k < NCTR; k++) exp_app[k] = exp_live[k];
        check_seqs("R9");
        step(7'b0, 1'b0, 1'b1);
        check_seqs("R9");
        check_bank(1'b1, "R9");
    endtask

    initial begin
        for (int k = 0; k < NCTR; k++) begin
            exp_live[k] = '0; exp_os[k] = '0; exp_app[k] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_counting();
        t_coincident();
        t_independent();
        t_bad_index();
        t_periodic();
        t_div_zero();
        t_seq_wrap();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule